// File: doc/BRIEF.md
# I2C Master Single-Primitive Command Engine

This block is an I2C bus master that software steers one bus primitive at a time through a small byte-wide register set. A command code is written together with a launch bit. The engine then performs exactly one primitive on the bus and stops. The primitives are a start condition, a repeated start, one transmitted byte with its acknowledge sampled, one received byte answered with ACK or NACK, and a stop condition. There is no automatic sequencing of bytes: the controlling software chains the primitives itself.

When a primitive ends, a two-bit completion code is latched and a pending flag is raised. The flag drives a level interrupt through an enable bit. The bus clock is derived from the module clock by a programmable divider. A control bit holds the engine in a local reset. Both open-drain pads are modelled as an output-enable (1 pulls the line low) and an input that reads the line.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, every register reads zero (control 0x0, divider 0x1, command 0x2, data 0x3, flag 0x8, enable 0xA), both pads are released and the interrupt is low.
- R2: A write to 0x2 with bit 7 set and a code of 1, 2, 3, 6, 7 or 10 in bits 3:0 launches a primitive, and bit 7 then reads 1 until it ends. A write without bit 7, with any other code, or while bit 7 still reads 1 changes neither the bus nor the code field in bits 3:0.
- R3: With value C in register 0x1, every quarter of a bus bit lasts 16×(C+1) module cycles. Codes 1, 2 and 10 take four quarters, and codes 3, 6 and 7 take nine bits of four quarters. Bit 7 of 0x2 clears, and the flag sets, on exactly the clock edge that ends the last quarter.
- R4: Code 3 shifts the data register out MSB first. Each bit pulls SCL low in quarters 0 and 3 and releases it in quarters 1 and 2. SDA changes only at the start of quarter 0, while SCL is low, and SDA is released during the ninth bit.
- R5: After code 3, bits 6:5 of 0x2 read 1 if SDA was low at the ninth-bit sample and 2 if it was high.
- R6: Codes 6 and 7 release SDA for eight bits and sample it at the end of quarter 1, MSB first, into the data register. In the ninth bit, code 6 pulls SDA low and code 7 releases it. The completion code reads 0.
- R7: Codes 1 and 2 pull SCL low in quarter 0, release both lines in quarter 1, pull SDA low in quarter 2 and pull SCL low in quarter 3, and leave both lines pulled low afterwards. Code 10 pulls both lines low in quarter 0, releases SCL in quarter 1, releases SDA in quarter 2, and leaves both lines released.
- R8: If SDA reads low at a quarter-1 sample while the engine releases it, during a start, a repeated start or a transmitted data bit, the primitive ends on that edge with code 3 and both lines released.
- R9: The flag reads in bit 0 of 0x8. Writing 1 to 0x8 clears it. The interrupt output equals the flag while bit 0 of 0xA is 1, and is low otherwise.
- R10: An external device that holds SCL low during quarter 1 pauses the engine, and completion moves later by exactly the number of stalled cycles.
- R11: While bit 0 of 0x0 is 1, a running primitive is cancelled, both lines are released, bit 7, the completion code and the flag read 0, and launches are ignored. Writing 0 restores normal operation with the divider value kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq | output | 1 | Level interrupt |
| scl_oe | output | 1 | 1 pulls SCL low |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | SDA line level |

## Verification
Every result lands at a cycle count after the launching write that follows from the divider. Pad levels settle inside each quarter, and sampled bits land at the end of quarter 1. Completion falls 64×(C+1) cycles after the launch for a single-bit primitive and 576×(C+1) for a byte primitive. An abort falls at the sample edge of the offending bit, and a stretch shifts completion by the stall length. The bench restarts its own cycle count on the launching edge and reads pads and registers on falling edges, at mid-quarter and at the cycles just before and just at each of these edges. The slave response is driven from that count, so every expected value comes from the arithmetic above and not from the design.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    OP_START     = 4'd1,
    OP_RESTART   = 4'd2,
    OP_SEND      = 4'd3,
    OP_RECV_ACK  = 4'd6,
    OP_RECV_NACK = 4'd7,
    OP_STOP      = 4'd10
  } op_e;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_ACK    = 2'd1,
    ST_NACK   = 2'd2,
    ST_ABORT  = 2'd3
  } status_e;

  localparam logic [3:0] A_CTRL  = 4'h0;
  localparam logic [3:0] A_CLKT  = 4'h1;
  localparam logic [3:0] A_CMD   = 4'h2;
  localparam logic [3:0] A_DATA  = 4'h3;
  localparam logic [3:0] A_IFCLR = 4'h8;
  localparam logic [3:0] A_IEN   = 4'hA;

  // True for the codes that launch a primitive
  function automatic logic op_known(input logic [3:0] c);
    case (c)
      4'd1, 4'd2, 4'd3, 4'd6, 4'd7, 4'd10: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Primitives that move a byte plus an acknowledge bit
  function automatic logic op_has_byte(input op_e o);
    return (o == OP_SEND) || (o == OP_RECV_ACK) || (o == OP_RECV_NACK);
  endfunction

  // Terminal count of one quarter: mult*(field+1) cycles
  function automatic logic [31:0] quarter_last(input logic [31:0] field,
                                               input logic [31:0] mult);
    return mult * (field + 32'd1) - 32'd1;
  endfunction

endpackage

// File: rtl/i2c_cmd_qtimer.sv
module i2c_cmd_qtimer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             stall,
  input  logic [CNT_W-1:0] last,
  output logic [1:0]       quarter,
  output logic             q_end
);

  logic [CNT_W-1:0] cnt;

  assign q_end = run && !stall && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      quarter <= '0;
    end else if (clr) begin
      cnt     <= '0;
      quarter <= '0;
    end else if (run && !stall) begin
      if (cnt == last) begin
        cnt     <= '0;
        quarter <= quarter + 2'd1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= last));

  assert_stall_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && stall && !clr) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2c_cmd_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int DIV_W        = 8,
  parameter int QUARTER_MULT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              launch,
  input  logic [3:0]        launch_op,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic [DIV_W-1:0]  div_field,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              busy,
  output logic              done,
  output logic              rx_load,
  output logic [1:0]        done_status,
  output logic [DATA_W-1:0] rx_byte,
  output logic              scl_oe,
  output logic              sda_oe
);

  localparam int CNT_W  = $clog2(QUARTER_MULT * (1 << DIV_W));
  localparam int SLOT_W = $clog2(DATA_W + 1);

  op_e               op_q;
  logic [SLOT_W-1:0] slot;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  last_q;
  logic              ack_q, scl_hold, sda_hold;
  logic [1:0]        quarter;
  logic              q_end, stall, sample, q_last;
  logic              drv_scl, drv_sda;
  logic              has_byte, ack_slot, last_slot, is_start, is_send, is_recv;
  logic              abort_hit, finish;

  assign has_byte  = op_has_byte(op_q);
  assign ack_slot  = has_byte && (slot == SLOT_W'(DATA_W));
  assign last_slot = has_byte ? ack_slot : 1'b1;
  assign is_start  = (op_q == OP_START) || (op_q == OP_RESTART);
  assign is_send   = (op_q == OP_SEND);
  assign is_recv   = (op_q == OP_RECV_ACK) || (op_q == OP_RECV_NACK);

  // SCL is released in quarter 1; a low line there means stretching
  assign stall = busy && (quarter == 2'd1) && !scl_in;

  i2c_cmd_qtimer #(.CNT_W(CNT_W)) u_qtimer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (launch || soft_rst),
    .run     (busy),
    .stall   (stall),
    .last    (last_q),
    .quarter (quarter),
    .q_end   (q_end)
  );

  assign sample = q_end && (quarter == 2'd1);
  assign q_last = q_end && (quarter == 2'd3);

  // Pad pattern for the current quarter (1 = pull low)
  always_comb begin
    drv_scl = (quarter == 2'd0) || (quarter == 2'd3);
    drv_sda = 1'b0;
    if (is_start) begin
      drv_sda = quarter[1];
    end else if (op_q == OP_STOP) begin
      drv_scl = (quarter == 2'd0);
      drv_sda = !quarter[1];
    end else if (is_send) begin
      drv_sda = !ack_slot && !shreg[DATA_W-1];
    end else if (is_recv) begin
      drv_sda = ack_slot && (op_q == OP_RECV_ACK);
    end
  end

  assign abort_hit = busy && sample && !sda_in && !drv_sda &&
                     (is_start || (is_send && !ack_slot));
  assign finish    = busy && (abort_hit || (q_last && last_slot));

  assign done        = finish;
  assign rx_load     = finish && !abort_hit && is_recv;
  assign rx_byte     = shreg;
  assign done_status = abort_hit ? ST_ABORT :
                       is_send   ? (ack_q ? ST_ACK : ST_NACK) : ST_NORMAL;

  assign scl_oe = busy ? drv_scl : scl_hold;
  assign sda_oe = busy ? drv_sda : sda_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      op_q     <= OP_START;
      slot     <= '0;
      shreg    <= '0;
      ack_q    <= 1'b0;
      last_q   <= '0;
      scl_hold <= 1'b0;
      sda_hold <= 1'b0;
    end else if (soft_rst) begin
      busy     <= 1'b0;
      scl_hold <= 1'b0;
      sda_hold <= 1'b0;
    end else if (launch) begin
      busy   <= 1'b1;
      op_q   <= op_e'(launch_op);
      slot   <= '0;
      shreg  <= tx_byte;
      ack_q  <= 1'b0;
      last_q <= CNT_W'(quarter_last(32'(div_field), 32'(QUARTER_MULT)));
    end else if (busy) begin
      if (finish) begin
        busy     <= 1'b0;
        scl_hold <= !abort_hit && drv_scl;
        sda_hold <= !abort_hit && drv_sda;
      end
      if (sample && ack_slot) ack_q <= !sda_in;
      if (sample && is_recv && !ack_slot) shreg <= {shreg[DATA_W-2:0], sda_in};
      if (q_last && is_send && !ack_slot) shreg <= {shreg[DATA_W-2:0], 1'b0};
      if (q_last && !last_slot) slot <= slot + 1'b1;
    end
  end

  assert_sda_moves_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (is_send || is_recv) && (sda_oe != $past(sda_oe)))
      |-> scl_oe);

  assert_abort_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (done_status == ST_ABORT)) |=> (!scl_oe && !sda_oe));

  assert_slot_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (slot <= SLOT_W'(DATA_W)));

endmodule

// File: rtl/i2c_cmd_regs.sv
module i2c_cmd_regs
  import i2c_cmd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic              eng_rx_load,
  input  logic [1:0]        eng_status,
  input  logic [BYTE_W-1:0] eng_rx,
  output logic              launch,
  output logic [3:0]        launch_op,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [DIV_W-1:0]  div_field,
  output logic              soft_rst,
  output logic              irq
);

  logic              ctrl_rst, flag, ien;
  logic [DIV_W-1:0]  clkt;
  logic [BYTE_W-1:0] data_q;
  logic [1:0]        status;
  logic [3:0]        cmd_code;

  assign launch = reg_wr && (reg_addr == A_CMD) && reg_wdata[7] && !eng_busy &&
                  !ctrl_rst && op_known(reg_wdata[3:0]);
  assign launch_op = reg_wdata[3:0];
  assign tx_byte   = data_q;
  assign div_field = clkt;
  assign soft_rst  = ctrl_rst;
  assign irq       = flag && ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_rst <= 1'b0;
      clkt     <= '0;
      data_q   <= '0;
      ien      <= 1'b0;
      flag     <= 1'b0;
      status   <= '0;
      cmd_code <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL:  ctrl_rst <= reg_wdata[0];
          A_CLKT:  clkt     <= DIV_W'(reg_wdata);
          A_DATA:  data_q   <= reg_wdata;
          A_IEN:   ien      <= reg_wdata[0];
          default: ;
        endcase
      end
      if (launch) cmd_code <= reg_wdata[3:0];
      if (eng_rx_load) data_q <= eng_rx;
      if (ctrl_rst) begin
        flag   <= 1'b0;
        status <= '0;
      end else begin
        if (reg_wr && (reg_addr == A_IFCLR) && reg_wdata[0]) flag <= 1'b0;
        if (eng_done) begin
          flag   <= 1'b1;
          status <= eng_status;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {7'd0, ctrl_rst};
      A_CLKT:  reg_rdata = BYTE_W'(clkt);
      A_CMD:   reg_rdata = {eng_busy, status, 1'b0, cmd_code};
      A_DATA:  reg_rdata = data_q;
      A_IFCLR: reg_rdata = {7'd0, flag};
      A_IEN:   reg_rdata = {7'd0, ien};
      default: reg_rdata = '0;
    endcase
  end

  assert_flag_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !ctrl_rst) |=> flag);

  assert_ignore_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && reg_wr && (reg_addr == A_CMD)) |=> $stable(cmd_code));

endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int DIV_W        = 8,
  parameter int QUARTER_MULT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_oe,
  input  logic       scl_in,
  output logic       sda_oe,
  input  logic       sda_in
);

  logic              launch, soft_rst, busy, done, rx_load;
  logic [3:0]        launch_op;
  logic [BYTE_W-1:0] tx_byte, rx_byte;
  logic [DIV_W-1:0]  div_field;
  logic [1:0]        done_status;

  i2c_cmd_regs #(.DIV_W(DIV_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .eng_busy    (busy),
    .eng_done    (done),
    .eng_rx_load (rx_load),
    .eng_status  (done_status),
    .eng_rx      (rx_byte),
    .launch      (launch),
    .launch_op   (launch_op),
    .tx_byte     (tx_byte),
    .div_field   (div_field),
    .soft_rst    (soft_rst),
    .irq         (irq)
  );

  i2c_cmd_engine #(
    .DATA_W       (BYTE_W),
    .DIV_W        (DIV_W),
    .QUARTER_MULT (QUARTER_MULT)
  ) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .launch      (launch),
    .launch_op   (launch_op),
    .tx_byte     (tx_byte),
    .div_field   (div_field),
    .scl_in      (scl_in),
    .sda_in      (sda_in),
    .busy        (busy),
    .done        (done),
    .rx_load     (rx_load),
    .done_status (done_status),
    .rx_byte     (rx_byte),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe)
  );

  assert_launch_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  assert_reset_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) && soft_rst |-> (!busy && !scl_oe && !sda_oe));

endmodule

// File: tb/tb_i2c_cmd_master.sv
module tb_i2c_cmd_master;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  wire  [7:0] rdata;
  wire        irq, scl_oe, sda_oe;
  logic       scl_in, sda_in;

  logic       stretch = 1'b0;
  logic       pull_en = 1'b0;
  logic [8:0] resp = '0;
  logic       arm = 1'b0;
  int         since = 0;
  int         qlen = 16;
  int         slot;
  int         checks = 0, fails = 0;
  logic [7:0] v, b;
  logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h3C};

  always #5 clk = ~clk;

  // Open-drain bus with a slave that follows the bench cycle count
  assign slot   = since / (4 * qlen);
  assign scl_in = !scl_oe && !stretch;
  assign sda_in = !sda_oe && !(pull_en && (slot < 9) && resp[slot[3:0]]);

  always @(posedge clk) since <= (wr && arm) ? 0 : since + 1;

  i2c_cmd_master dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq(irq), .scl_oe(scl_oe), .scl_in(scl_in),
    .sda_oe(sda_oe), .sda_in(sda_in)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic launch(input int code);
    arm = 1'b1;
    wreg(4'h2, 8'h80 | 8'(code));
    arm = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_since(input int k);
    while (since < k) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rreg(4'h0, v); chk("R1 control", v, 0);
    rreg(4'h1, v); chk("R1 divider", v, 0);
    rreg(4'h2, v); chk("R1 command", v, 0);
    rreg(4'h3, v); chk("R1 data", v, 0);
    rreg(4'h8, v); chk("R1 flag", v, 0);
    rreg(4'hA, v); chk("R1 enable", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 scl released", scl_oe, 0);
    chk("R1 sda released", sda_oe, 0);

    wreg(4'hA, 8'h01);

    // R3 / R7 divider sweep over start and stop
    for (int c = 0; c < 4; c++) begin
      wreg(4'h1, 8'(c));
      qlen = 16 * (c + 1);
      for (int w = 0; w < 2; w++) begin
        launch(w ? 10 : 1);
        for (int q = 0; q < 4; q++) begin
          wait_since(q * qlen + qlen / 2);
          chk("R7 scl quarter", scl_oe, w ? int'(q == 0) : int'(q == 0 || q == 3));
          chk("R7 sda quarter", sda_oe, w ? int'(q <= 1) : int'(q >= 2));
        end
        wait_since(4 * qlen - 1);
        rreg(4'h2, v); chk("R3 busy before end", v[7], 1);
        chk("R9 no irq before end", irq, 0);
        wait_since(4 * qlen);
        rreg(4'h2, v); chk("R3 go cleared at end", v[7], 0);
        chk("R3 code", v[6:0], w ? 10 : 1);
        chk("R9 irq at end", irq, 1);
        chk("R7 held scl", scl_oe, w ? 0 : 1);
        chk("R7 held sda", sda_oe, w ? 0 : 1);
        wreg(4'h8, 8'h01);
        rreg(4'h8, v); chk("R9 flag cleared", v, 0);
        chk("R9 irq cleared", irq, 0);
      end
    end

    // R2 ignored writes
    wreg(4'h1, 8'h00); qlen = 16;
    wreg(4'h2, 8'h01);
    repeat (4) @(negedge clk);
    rreg(4'h2, v); chk("R2 no go bit ignored", v, 8'h0A);
    chk("R2 no go bus idle", scl_oe, 0);
    wreg(4'h2, 8'h85);
    repeat (4) @(negedge clk);
    rreg(4'h2, v); chk("R2 unknown code ignored", v, 8'h0A);
    chk("R2 unknown code bus idle", scl_oe, 0);
    launch(1);
    wait_since(10);
    rreg(4'h2, v); chk("R2 go reads one", v, 8'h81);
    wreg(4'h2, 8'h8A);
    rreg(4'h2, v); chk("R2 busy write ignored", v, 8'h81);
    wait_since(63);
    rreg(4'h2, v); chk("R2 busy kept timing", v[7], 1);
    wait_since(64);
    rreg(4'h2, v); chk("R2 original code done", v, 8'h01);
    chk("R2 no stop ran scl", scl_oe, 1);
    chk("R2 no stop ran sda", sda_oe, 1);
    wreg(4'h8, 8'h01);

    // R4 / R5 transmit sweep
    for (int i = 0; i < 5; i++) begin
      for (int a = 0; a < 2; a++) begin
        b = pats[i];
        wreg(4'h3, b);
        resp = a ? 9'h100 : 9'h000;
        pull_en = 1'b1;
        launch(3);
        for (int k = 0; k < 8; k++) begin
          wait_since(k * 64 + 8);
          chk("R4 data bit q0", sda_oe, int'(!b[7-k]));
          chk("R4 scl low q0", scl_oe, 1);
          wait_since(k * 64 + 24);
          chk("R4 scl released q1", scl_oe, 0);
          chk("R4 data stable q1", sda_oe, int'(!b[7-k]));
          wait_since(k * 64 + 56);
          chk("R4 scl low q3", scl_oe, 1);
        end
        wait_since(8 * 64 + 24);
        chk("R4 ack bit released", sda_oe, 0);
        wait_since(575);
        rreg(4'h2, v); chk("R3 byte busy", v[7], 1);
        wait_since(576);
        rreg(4'h2, v); chk("R5 status", v, a ? 8'h23 : 8'h43);
        pull_en = 1'b0;
        wreg(4'h8, 8'h01);
      end
    end

    // R6 receive sweep
    for (int i = 0; i < 4; i++) begin
      b = pats[(i + 2) % 5];
      for (int k = 0; k < 8; k++) resp[k] = !b[7-k];
      resp[8] = 1'b0;
      pull_en = 1'b1;
      launch((i % 2) ? 7 : 6);
      wait_since(3 * 64 + 24);
      chk("R6 sda released in data", sda_oe, 0);
      wait_since(8 * 64 + 24);
      chk("R6 answer bit", sda_oe, (i % 2) ? 0 : 1);
      wait_since(576);
      pull_en = 1'b0;
      rreg(4'h3, v); chk("R6 received byte", v, b);
      rreg(4'h2, v); chk("R6 status normal", v, (i % 2) ? 8'h07 : 8'h06);
      wreg(4'h8, 8'h01);
    end

    // R8 abort during start and during a transmitted bit
    resp = 9'h001; pull_en = 1'b1;
    launch(1);
    wait_since(31);
    rreg(4'h2, v); chk("R8 start busy", v[7], 1);
    wait_since(32);
    rreg(4'h2, v); chk("R8 start abort", v, 8'h61);
    chk("R8 start scl released", scl_oe, 0);
    chk("R8 start sda released", sda_oe, 0);
    wreg(4'h8, 8'h01);
    wreg(4'h3, 8'h40);
    resp = 9'h002;
    launch(3);
    wait_since(95);
    rreg(4'h2, v); chk("R8 send busy", v[7], 1);
    wait_since(96);
    rreg(4'h2, v); chk("R8 send abort", v, 8'h63);
    chk("R8 send lines released", scl_oe | sda_oe, 0);
    pull_en = 1'b0;
    wreg(4'h8, 8'h01);

    // R10 clock stretch
    launch(1);
    wait_since(16);
    stretch = 1'b1;
    wait_since(24);
    chk("R10 scl released while stretched", scl_oe, 0);
    wait_since(36);
    stretch = 1'b0;
    wait_since(83);
    rreg(4'h2, v); chk("R10 still busy", v[7], 1);
    wait_since(84);
    rreg(4'h2, v); chk("R10 delayed completion", v[7], 0);

    // R9 enable gating with flag pending
    wreg(4'hA, 8'h00);
    chk("R9 irq masked", irq, 0);
    rreg(4'h8, v); chk("R9 flag kept when masked", v, 1);
    wreg(4'hA, 8'h01);
    chk("R9 irq unmasked", irq, 1);

    // R11 local reset
    wreg(4'h3, 8'h55);
    launch(3);
    wait_since(100);
    wreg(4'h0, 8'h01);
    @(negedge clk);
    rreg(4'h0, v); chk("R11 control reads set", v, 1);
    rreg(4'h2, v); chk("R11 go and status cleared", v[7:5], 0);
    rreg(4'h8, v); chk("R11 flag cleared", v, 0);
    chk("R11 irq low", irq, 0);
    chk("R11 lines released", scl_oe | sda_oe, 0);
    wreg(4'h2, 8'h81);
    repeat (5) @(negedge clk);
    rreg(4'h2, v); chk("R11 launch ignored", v[7], 0);
    chk("R11 bus idle", scl_oe, 0);
    wreg(4'h0, 8'h00);
    launch(1);
    wait_since(63);
    rreg(4'h2, v); chk("R11 runs after release", v[7], 1);
    wait_since(64);
    rreg(4'h8, v); chk("R11 flag after release", v, 1);
    rreg(4'h1, v); chk("R11 divider kept", v, 0);

    finish_run();
  end

endmodule